// File: doc/BRIEF.md
# Checkpoint-Tagged Rollback Log

This block sits next to a cache or memory controller and keeps enough history to rewind the block array to the last validated checkpoint. Every block carries a checkpoint tag beside its coherence state and data. When a store or an ownership transfer touches a block for the first time in the active checkpoint interval, the block's previous address, state and data are pushed into a log, together with the active checkpoint number. The block's tag then moves to the active checkpoint. Later writes to that block in the same interval add nothing to the log.

A validate command advances the recovery point. Log entries that belong to checkpoints at or before it are then released from the oldest end, one per cycle. A recover command unwinds the log from the newest end and writes each entry back into the block array. It stops when the log is empty or the newest remaining entry is at or before the recovery point. When the log is full, any event that would need a log entry is held back until space frees. The block array is a small register file inside this block. Loads read it through a registered port.

Top module: `ckpt_log_buffer`

## Requirements
- R1: After synchronous reset the log is empty (log_count 0, log_full 0), busy is 0 and ev_ready is 1. Every block reads back with state 0 (invalid) and data 0, and has tag 0. The recovery point is 0.
- R2: ev_kind 1 is a store. It is accepted in a cycle where ev_valid and ev_ready are both high. If the block's tag differs from cur_cn, the store adds exactly one log entry. After the store the block holds ev_data with state 3 (modified), and its tag is cur_cn.
- R3: A store to a block whose tag already equals cur_cn leaves log_count unchanged.
- R4: ev_kind 2 is an ownership transfer. It logs under the same first-per-interval rule as a store. It sets the block's state to 0 and keeps the data.
- R5: ev_kind 0 is a load. A load never changes log_count. One cycle after acceptance, rd_valid is 1 and rd_state/rd_data show the block.
- R6: log_count never exceeds LOG_DEPTH, and log_full is 1 exactly when the log holds LOG_DEPTH entries. While the log is full, a store or transfer that needs logging sees ev_ready 0 and has no effect. An event that needs no logging is still accepted.
- R7: validate_valid loads validate_cn as the new recovery point. From the next cycle on, while the oldest entry's checkpoint is at or before the recovery point (modular compare), that entry is removed at a rate of one per cycle.
- R8: recover_valid makes busy 1 from the next cycle, and ev_ready stays 0 while busy. Each busy cycle pops the newest entry whose checkpoint is later than the recovery point and restores that entry's address, state and data. Busy falls when no such entry is left.
- R9: A block restored by recovery is retagged with the recovery point. The first store to it in any later checkpoint is therefore logged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event request |
| ev_kind | input | 2 | 0 load, 1 store, 2 ownership transfer, 3 no operation |
| ev_addr | input | ADDR_W | Block index |
| ev_data | input | DATA_W | Store data |
| cur_cn | input | CN_W | Active checkpoint number |
| validate_valid | input | 1 | Advance the recovery point |
| validate_cn | input | CN_W | New recovery point |
| recover_valid | input | 1 | Start rollback to the recovery point |
| ev_ready | output | 1 | Event accepted this cycle if valid |
| log_full | output | 1 | Log holds LOG_DEPTH entries |
| log_count | output | CNT_W | Entries in the log |
| busy | output | 1 | Rollback in progress |
| rd_valid | output | 1 | Load result valid |
| rd_state | output | 2 | Load result state |
| rd_data | output | DATA_W | Load result data |

## Verification
The assertions assume that checkpoint numbers stay within half the tag range of the recovery point, so that the modular compare stays ordered. They also assume that validate is not issued while a rollback is running, and that recover_valid is a single-cycle pulse. The stimulus only raises cur_cn in small steps above the recovery point, pulses validate and recover for one cycle each, and waits for busy to fall before it issues any further command. With these limits the count assertions can treat every decrease as either a drain or a rollback pop.

// File: rtl/ckpt_log_pkg.sv
package ckpt_log_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_OWN = 2'd2,
    ST_MOD = 2'd3
  } blk_state_e;

  typedef enum logic [1:0] {
    EV_LOAD  = 2'd0,
    EV_STORE = 2'd1,
    EV_XFER  = 2'd2,
    EV_NOP   = 2'd3
  } ev_kind_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_ROLL = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/ckpt_block_array.sv
module ckpt_block_array #(
  parameter int N_BLOCKS = 8,
  parameter int DATA_W   = 16,
  parameter int CN_W     = 8,
  localparam int ADDR_W  = $clog2(N_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_state,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CN_W-1:0]   wr_tag,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_state,
  output logic [DATA_W-1:0] rd_data,
  output logic [CN_W-1:0]   rd_tag
);
  logic [1:0]        st_q  [N_BLOCKS];
  logic [DATA_W-1:0] dat_q [N_BLOCKS];
  logic [CN_W-1:0]   tag_q [N_BLOCKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_BLOCKS; i++) begin
        st_q[i]  <= 2'd0;
        dat_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_addr]  <= wr_state;
      dat_q[wr_addr] <= wr_data;
      tag_q[wr_addr] <= wr_tag;
    end
  end

  assign rd_state = st_q[rd_addr];
  assign rd_data  = dat_q[rd_addr];
  assign rd_tag   = tag_q[rd_addr];
endmodule

// File: rtl/ckpt_log_fifo.sv
module ckpt_log_fifo #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CN_W   = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = ADDR_W + 2 + DATA_W + CN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [1:0]        push_state,
  input  logic [DATA_W-1:0] push_data,
  input  logic [CN_W-1:0]   push_cn,
  input  logic              pop_head,
  input  logic              pop_tail,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  output logic [CN_W-1:0]   head_cn,
  output logic [ADDR_W-1:0] last_addr,
  output logic [1:0]        last_state,
  output logic [DATA_W-1:0] last_data,
  output logic [CN_W-1:0]   last_cn
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, last_idx;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign last_idx = ptr_dec(tail_q);

  always_ff @(posedge clk) begin
    if (push)
      mem[tail_q] <= {push_addr, push_state, push_data, push_cn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)
        tail_q <= ptr_inc(tail_q);
      else if (pop_tail)
        tail_q <= last_idx;
      if (pop_head)
        head_q <= ptr_inc(head_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop_head) - CNT_W'(pop_tail);
    end
  end

  assign count   = cnt_q;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign head_cn = mem[head_q][CN_W-1:0];
  assign {last_addr, last_state, last_data, last_cn} = mem[last_idx];
endmodule

// File: rtl/ckpt_log_ctrl.sv
module ckpt_log_ctrl
  import ckpt_log_pkg::*;
#(
  parameter int CN_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  logic [1:0]      ev_kind,
  input  logic [CN_W-1:0] blk_tag,
  input  logic [CN_W-1:0] cur_cn,
  input  logic            validate_valid,
  input  logic [CN_W-1:0] validate_cn,
  input  logic            recover_valid,
  input  logic            log_empty,
  input  logic            log_full,
  input  logic [CN_W-1:0] head_cn,
  input  logic [CN_W-1:0] last_cn,
  output logic            ev_ready,
  output logic            ev_accept,
  output logic            log_push,
  output logic            pop_head,
  output logic            pop_tail,
  output logic            busy,
  output logic [CN_W-1:0] rp_cn
);
  ctl_state_e      st_q;
  logic [CN_W-1:0] rp_q;
  logic            modifies, need_log, last_newer, head_newer;

  function automatic logic cn_later(input logic [CN_W-1:0] a, input logic [CN_W-1:0] b);
    logic [CN_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[CN_W-1];
  endfunction

  assign modifies   = (ev_kind == EV_STORE) || (ev_kind == EV_XFER);
  assign need_log   = modifies && (blk_tag != cur_cn);
  assign head_newer = cn_later(head_cn, rp_q);
  assign last_newer = cn_later(last_cn, rp_q);

  assign ev_ready  = (st_q == CS_IDLE) && !recover_valid && !(need_log && log_full);
  assign ev_accept = ev_valid && ev_ready;
  assign log_push  = ev_accept && need_log;
  assign pop_head  = (st_q == CS_IDLE) && !log_empty && !head_newer;
  assign pop_tail  = (st_q == CS_ROLL) && !log_empty && last_newer;
  assign busy      = (st_q == CS_ROLL);
  assign rp_cn     = rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= CS_IDLE;
      rp_q <= '0;
    end else begin
      case (st_q)
        CS_IDLE: begin
          if (validate_valid)
            rp_q <= validate_cn;
          if (recover_valid)
            st_q <= CS_ROLL;
        end
        default: begin
          if (!pop_tail)
            st_q <= CS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ckpt_log_buffer.sv
module ckpt_log_buffer
  import ckpt_log_pkg::*;
#(
  parameter int N_BLOCKS  = 8,
  parameter int DATA_W    = 16,
  parameter int CN_W      = 8,
  parameter int LOG_DEPTH = 8,
  localparam int ADDR_W   = $clog2(N_BLOCKS),
  localparam int CNT_W    = $clog2(LOG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic [CN_W-1:0]   cur_cn,
  input  logic              validate_valid,
  input  logic [CN_W-1:0]   validate_cn,
  input  logic              recover_valid,
  output logic              ev_ready,
  output logic              log_full,
  output logic [CNT_W-1:0]  log_count,
  output logic              busy,
  output logic              rd_valid,
  output logic [1:0]        rd_state,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0]        blk_state;
  logic [DATA_W-1:0] blk_data;
  logic [CN_W-1:0]   blk_tag;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [1:0]        wr_state;
  logic [DATA_W-1:0] wr_data;
  logic [CN_W-1:0]   wr_tag;
  logic              ev_accept, log_push, pop_head, pop_tail, log_empty;
  logic [CN_W-1:0]   head_cn, last_cn, rp_cn;
  logic [ADDR_W-1:0] last_addr;
  logic [1:0]        last_state;
  logic [DATA_W-1:0] last_data;

  ckpt_block_array #(.N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W), .CN_W(CN_W)) u_blocks (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_state(wr_state), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_addr(ev_addr), .rd_state(blk_state), .rd_data(blk_data), .rd_tag(blk_tag)
  );

  ckpt_log_fifo #(.DEPTH(LOG_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CN_W(CN_W)) u_log (
    .clk(clk), .rst(rst),
    .push(log_push), .push_addr(ev_addr), .push_state(blk_state), .push_data(blk_data),
    .push_cn(cur_cn), .pop_head(pop_head), .pop_tail(pop_tail),
    .empty(log_empty), .full(log_full), .count(log_count), .head_cn(head_cn),
    .last_addr(last_addr), .last_state(last_state), .last_data(last_data), .last_cn(last_cn)
  );

  ckpt_log_ctrl #(.CN_W(CN_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .blk_tag(blk_tag), .cur_cn(cur_cn),
    .validate_valid(validate_valid), .validate_cn(validate_cn), .recover_valid(recover_valid),
    .log_empty(log_empty), .log_full(log_full), .head_cn(head_cn), .last_cn(last_cn),
    .ev_ready(ev_ready), .ev_accept(ev_accept), .log_push(log_push),
    .pop_head(pop_head), .pop_tail(pop_tail), .busy(busy), .rp_cn(rp_cn)
  );

  // Write port: rollback restore has the port while busy, else accepted stores/transfers.
  always_comb begin
    wr_en    = 1'b0;
    wr_addr  = ev_addr;
    wr_state = blk_state;
    wr_data  = blk_data;
    wr_tag   = cur_cn;
    if (pop_tail) begin
      wr_en    = 1'b1;
      wr_addr  = last_addr;
      wr_state = last_state;
      wr_data  = last_data;
      wr_tag   = rp_cn;
    end else if (ev_accept && ev_kind == EV_STORE) begin
      wr_en    = 1'b1;
      wr_state = ST_MOD;
      wr_data  = ev_data;
    end else if (ev_accept && ev_kind == EV_XFER) begin
      wr_en    = 1'b1;
      wr_state = ST_INV;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_state <= 2'd0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ev_accept && (ev_kind == EV_LOAD);
      if (ev_accept && ev_kind == EV_LOAD) begin
        rd_state <= blk_state;
        rd_data  <= blk_data;
      end
    end
  end
endmodule

// File: rtl/ckpt_log_buffer_chk.sv
module ckpt_log_buffer_chk #(
  parameter int LOG_DEPTH = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [1:0]       ev_kind,
  input logic             ev_ready,
  input logic             log_full,
  input logic [CNT_W-1:0] log_count,
  input logic             busy,
  input logic             rd_valid
);
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (log_count == '0 && !busy));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    log_count <= CNT_W'(LOG_DEPTH));

  a_r6_full_no_growth: assert property (@(posedge clk) disable iff (rst)
    log_full |=> log_count <= $past(log_count));

  a_r5_load_no_log: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind == 2'd0) |=> (rd_valid && log_count <= $past(log_count)));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ev_ready);

  a_r8_roll_shrinks: assert property (@(posedge clk) disable iff (rst)
    busy |=> log_count <= $past(log_count));
endmodule

bind ckpt_log_buffer ckpt_log_buffer_chk #(.LOG_DEPTH(LOG_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_ready(ev_ready),
  .log_full(log_full), .log_count(log_count), .busy(busy), .rd_valid(rd_valid)
);

// File: tb/ckpt_log_buffer_tb_top.sv
module ckpt_log_buffer_tb_top;
  localparam int NB = 8, DW = 16, CW = 8, LD = 8;
  localparam int AW = $clog2(NB), CNTW = $clog2(LD + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic ev_valid = 1'b0, validate_valid = 1'b0, recover_valid = 1'b0;
  logic [1:0] ev_kind = 2'd3;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic [CW-1:0] cur_cn = '0, validate_cn = '0;
  logic ev_ready, log_full, busy, rd_valid;
  logic [CNTW-1:0] log_count;
  logic [1:0] rd_state;
  logic [DW-1:0] rd_data;

  int n_checks = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  ckpt_log_buffer #(.N_BLOCKS(NB), .DATA_W(DW), .CN_W(CW), .LOG_DEPTH(LD)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_data(ev_data), .cur_cn(cur_cn), .validate_valid(validate_valid),
    .validate_cn(validate_cn), .recover_valid(recover_valid), .ev_ready(ev_ready),
    .log_full(log_full), .log_count(log_count), .busy(busy), .rd_valid(rd_valid),
    .rd_state(rd_state), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [1:0] k, input int a, input logic [DW-1:0] d, input int cn);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_addr = AW'(a); ev_data = d; cur_cn = CW'(cn);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'd3;
  endtask

  task automatic load_chk(input string req, input int a, input int cn, input logic [1:0] st, input logic [DW-1:0] d);
    ev(2'd0, a, '0, cn);
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, {30'd0, rd_state}, {30'd0, st});
    chk(req, {16'd0, rd_data}, {16'd0, d});
  endtask

  task automatic validate(input int cn);
    @(negedge clk);
    validate_valid = 1'b1; validate_cn = CW'(cn);
    @(negedge clk);
    validate_valid = 1'b0;
    repeat (LD + 2) @(negedge clk);
  endtask

  task automatic recover();
    @(negedge clk);
    recover_valid = 1'b1;
    @(negedge clk);
    recover_valid = 1'b0;
    chk("R8 busy", {31'd0, busy}, 32'd1);
    chk("R8 ready low", {31'd0, ev_ready}, 32'd0);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk("R8 busy fell", {31'd0, busy}, 32'd0);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [7:0]  cn;
    logic [3:0]  cnt;
    logic [1:0]  st;
  } vec_t;

  // kind 0 load,1 store,2 transfer; cnt = expected log_count; st/data checked for loads
  localparam vec_t TBL [8] = '{
    '{kind: 2'd1, addr: 3'd0, data: 16'h1111, cn: 8'd1, cnt: 4'd1, st: 2'd0},  // R2
    '{kind: 2'd1, addr: 3'd0, data: 16'h2222, cn: 8'd1, cnt: 4'd1, st: 2'd0},  // R3
    '{kind: 2'd0, addr: 3'd0, data: 16'h2222, cn: 8'd1, cnt: 4'd1, st: 2'd3},  // R5
    '{kind: 2'd1, addr: 3'd1, data: 16'h3333, cn: 8'd1, cnt: 4'd2, st: 2'd0},  // R2
    '{kind: 2'd1, addr: 3'd0, data: 16'h4444, cn: 8'd2, cnt: 4'd3, st: 2'd0},  // R2 new interval
    '{kind: 2'd2, addr: 3'd1, data: 16'h0000, cn: 8'd2, cnt: 4'd4, st: 2'd0},  // R4
    '{kind: 2'd0, addr: 3'd1, data: 16'h3333, cn: 8'd2, cnt: 4'd4, st: 2'd0},  // R4 invalidated
    '{kind: 2'd2, addr: 3'd1, data: 16'h0000, cn: 8'd2, cnt: 4'd4, st: 2'd0}   // R4 no relog
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", {28'd0, log_count}, 32'd0);
    chk("R1 full", {31'd0, log_full}, 32'd0);
    chk("R1 ready", {31'd0, ev_ready}, 32'd1);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    load_chk("R1 block", 3, 0, 2'd0, 16'h0);

    for (int i = 0; i < 8; i++) begin
      ev(TBL[i].kind, int'(TBL[i].addr), TBL[i].data, int'(TBL[i].cn));
      chk($sformatf("R2/R3/R4 row%0d count", i), {28'd0, log_count}, {28'd0, TBL[i].cnt});
      if (TBL[i].kind == 2'd0) begin
        chk($sformatf("R5 row%0d valid", i), {31'd0, rd_valid}, 32'd1);
        chk($sformatf("R5 row%0d state", i), {30'd0, rd_state}, {30'd0, TBL[i].st});
        chk($sformatf("R5 row%0d data", i), {16'd0, rd_data}, {16'd0, TBL[i].data});
      end
    end

    // R7: validating checkpoint 1 frees the two oldest entries
    validate(1);
    chk("R7 drained", {28'd0, log_count}, 32'd2);

    // R8: roll back the two checkpoint-2 entries newest first
    recover();
    chk("R8 log empty", {28'd0, log_count}, 32'd0);
    load_chk("R8 a0 restored", 0, 2, 2'd3, 16'h2222);
    load_chk("R8 a1 restored", 1, 2, 2'd3, 16'h3333);

    // R9: restored block logs again in a later checkpoint
    ev(2'd1, 0, 16'h5555, 3);
    chk("R9 relog", {28'd0, log_count}, 32'd1);
    validate(3);
    chk("R7 drain cn3", {28'd0, log_count}, 32'd0);

    // R6: fill the log
    for (int a = 0; a < 8; a++) ev(2'd1, a, DW'(16'h0100 + a), 4);
    chk("R6 full count", {28'd0, log_count}, 32'd8);
    chk("R6 full flag", {31'd0, log_full}, 32'd1);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'd1; ev_addr = '0; ev_data = 16'hDEAD; cur_cn = 8'd5;
    #1;
    chk("R6 stall ready", {31'd0, ev_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'd3;
    chk("R6 stall count", {28'd0, log_count}, 32'd8);
    load_chk("R6 stalled no effect", 0, 5, 2'd3, 16'h0100);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 2'd1; ev_addr = '0; ev_data = 16'h7777; cur_cn = 8'd4;
    #1;
    chk("R6 unlogged accepted", {31'd0, ev_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'd3;
    chk("R6 unlogged count", {28'd0, log_count}, 32'd8);
    load_chk("R6 unlogged data", 0, 4, 2'd3, 16'h7777);

    // R8: full rollback to checkpoint 3
    recover();
    chk("R8 full unwind", {28'd0, log_count}, 32'd0);
    load_chk("R8 a0 back", 0, 4, 2'd3, 16'h5555);
    load_chk("R8 a2 back", 2, 4, 2'd0, 16'h0000);
    load_chk("R8 a7 back", 7, 4, 2'd0, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule